// File: doc/BRIEF.md
# Synthesizer Serial Control Register Bank

This block is the programming front end of a two-loop frequency synthesizer. A host shifts 24-bit words in on a three-wire link (data, shift clock, strobe), least significant bit first. On a rising strobe the block decodes the address prefix held in the most significant bits and copies the word's fields into one of four control registers. The four registers hold the main divider, the reference/lock/power settings, the auxiliary divider and the speed-up test controls. Words whose divider values fall below their minimum, whose spare or reserved bits are set, or whose prefix is unknown are rejected. A rejected word raises an error flag and leaves every register unchanged.

The register outputs go straight to the divider, charge-pump and speed-up logic. The block also turns each loop's stored power bit into an effective enable according to a polarity pin. It selects which of two lock-detect inputs reaches the lock pin and whether that pin is driven push-pull or as an open drain. The serial inputs are treated as already synchronous to the system clock. Each shift-clock or strobe rising edge is detected with one register stage.

Top module: `synth_ctl_bank`

## Requirements
- R1: After reset, the registers hold main ratio 2000, modulus select 0, increment 0, reference ratio 100, lock select 00, both power bits 0, compensation code 0, auxiliary ratio 400, charge-pump ratio 0, both comparison selects 0, both speed-up bits 0, and the error flag 0.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into bit 23 and moves the other bits down one place, so the first of 24 bits ends in bit 0. A rising `ser_strobe` whose bits [23:22] are 00 loads the main register from these fields: modulus select [21] (0 = modulo 8, 1 = modulo 5), increment [20:18], main ratio [17:2]. Bits [1:0] are spare.
- R3: Prefix 01 loads the reference register from these fields: ratio [21:12], lock select [11:10], main power bit [9], aux power bit [8], compensation code [7:0].
- R4: Prefix 10 loads the auxiliary register from these fields: ratio [21:8], charge-pump ratio [7:6], main comparison select [5:3], aux comparison select [2:0].
- R5: Prefix 110 in bits [23:21] loads the test register from these fields: speed-up disable [16], speed-up force-on [15]. If any of bits [20:17] or [14:0] is set, the word is rejected. Prefix 111 is always rejected.
- R6: A main word with a ratio below 512 or with nonzero spare bits is rejected. A ratio of exactly 512 is accepted.
- R7: A reference word with a ratio below 4, or an auxiliary word with a ratio below 128, is rejected. Ratios of exactly 4 and exactly 128 are accepted.
- R8: Each strobe sets `word_err` to 1 if the word is rejected and to 0 if it is accepted. A rejected word changes no register, and an accepted word changes only its own register.
- R9: With `pol_pin` low, a loop is enabled when its power bit is 1. With `pol_pin` high, a loop is enabled when its power bit is 0.
- R10: Lock select 00 gives push-pull combined lock, 01 gives open-drain combined lock, 10 gives main lock only and 11 gives aux lock only. Combined lock is the AND of the lock inputs of the enabled loops. In open-drain mode `lock_drive` is low whenever `lock_level` is high.
- R11: When both loops are disabled, `lock_level` is 0 and `lock_drive` is 1, whatever the lock select and lock inputs.
- R12: A load happens only on a rising edge of the strobe. Bits shifted while the strobe stays high are not loaded until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_strobe | input | 1 | Load strobe, rising edge loads |
| pol_pin | input | 1 | Power-bit polarity select |
| lock_main | input | 1 | Main loop lock-detect |
| lock_aux | input | 1 | Auxiliary loop lock-detect |
| mod_sel | output | 1 | Fractional modulus select |
| frac_inc | output | 3 | Fractional increment |
| main_div | output | 16 | Main divide ratio |
| ref_div | output | 10 | Reference divide ratio |
| comp_code | output | 8 | Fractional compensation code |
| aux_div | output | 14 | Auxiliary divide ratio |
| cp_ratio | output | 2 | Charge-pump current ratio |
| main_cmp | output | 3 | Main comparison select |
| aux_cmp | output | 3 | Auxiliary comparison select |
| spd_off | output | 1 | Speed-up disable |
| spd_on | output | 1 | Speed-up forced on |
| main_en | output | 1 | Effective main loop enable |
| aux_en | output | 1 | Effective auxiliary loop enable |
| word_err | output | 1 | Last strobed word rejected |
| lock_level | output | 1 | Lock pin logic level |
| lock_drive | output | 1 | Lock pin driver enable |

## Verification
Two events can coincide on the shift path: a shift-clock rising edge while the strobe is still held high from the previous load. The bench provokes this by loading one main word, keeping the strobe high and shifting a second main word in behind it. The scoreboard then expects the outputs to still show the first word after the strobe falls, and the second word only after a fresh rising strobe. A second coincidence is the power polarity flip against a stored lock select. Toggling `pol_pin` with the same reference register contents must move both effective enables and the lock pin together. The lock pin is judged against values worked out from the select code and the enabled loops.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int WORD_W = 24;
  localparam int N_W    = 16;
  localparam int R_W    = 10;
  localparam int A_W    = 14;
  localparam int FC_W   = 8;
  localparam int NSEL   = 4;
  localparam int SEL_MAIN = 0;
  localparam int SEL_REF  = 1;
  localparam int SEL_AUX  = 2;
  localparam int SEL_TEST = 3;

  typedef enum logic [1:0] {
    LK_COMB_PP = 2'b00,
    LK_COMB_OD = 2'b01,
    LK_MAIN    = 2'b10,
    LK_AUX     = 2'b11
  } lock_sel_e;

  typedef struct packed {
    logic [1:0]     addr;
    logic           fmod;
    logic [2:0]     frac;
    logic [N_W-1:0] ndiv;
    logic [1:0]     spare;
  } main_word_t;

  typedef struct packed {
    logic [1:0]      addr;
    logic [R_W-1:0]  rdiv;
    logic [1:0]      lsel;
    logic            pwr_main;
    logic            pwr_aux;
    logic [FC_W-1:0] fc;
  } ref_word_t;

  typedef struct packed {
    logic [1:0]     addr;
    logic [A_W-1:0] adiv;
    logic [1:0]     cp;
    logic [2:0]     sm;
    logic [2:0]     sa;
  } aux_word_t;

  typedef struct packed {
    logic [2:0]  addr;
    logic [3:0]  rsv_hi;
    logic        spd_dis;
    logic        spd_force;
    logic [14:0] rsv_lo;
  } test_word_t;

  typedef struct packed {
    logic           fmod;
    logic [2:0]     frac;
    logic [N_W-1:0] ndiv;
  } main_cfg_t;

  typedef struct packed {
    logic [R_W-1:0]  rdiv;
    lock_sel_e       lsel;
    logic            pwr_main;
    logic            pwr_aux;
    logic [FC_W-1:0] fc;
  } ref_cfg_t;

  typedef struct packed {
    logic [A_W-1:0] adiv;
    logic [1:0]     cp;
    logic [2:0]     sm;
    logic [2:0]     sa;
  } aux_cfg_t;

  typedef struct packed {
    logic spd_dis;
    logic spd_force;
  } test_cfg_t;
endpackage

// File: rtl/synth_shift.sv
module synth_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdata,
  input  logic         sclk,
  input  logic         sstb,
  output logic [W-1:0] word,
  output logic         load
);
  logic         sclk_q, stb_q, shift_en;
  logic [W-1:0] sreg_q, sreg_nx;

  always_comb begin
    shift_en = sclk & ~sclk_q;
    load     = sstb & ~stb_q;
    sreg_nx  = shift_en ? {sdata, sreg_q[W-1:1]} : sreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      stb_q  <= 1'b0;
      sreg_q <= '0;
    end else begin
      sclk_q <= sclk;
      stb_q  <= sstb;
      sreg_q <= sreg_nx;
    end
  end

  assign word = sreg_q;

  // R2: newest bit lands at the top of the word
  p_msb_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sreg_q[W-1] == $past(sdata));
  // R2: without a shift edge the register is frozen
  p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sreg_q));
endmodule

// File: rtl/synth_word_dec.sv
module synth_word_dec
  import synth_ctl_pkg::*;
#(
  parameter int N_MIN = 512,
  parameter int R_MIN = 4,
  parameter int A_MIN = 128
) (
  input  logic [WORD_W-1:0] word,
  output logic [NSEL-1:0]   sel,
  output logic              valid,
  output main_cfg_t         main_o,
  output ref_cfg_t          ref_o,
  output aux_cfg_t          aux_o,
  output test_cfg_t         test_o
);
  localparam logic [N_W-1:0] N_LIM = N_W'(N_MIN);
  localparam logic [R_W-1:0] R_LIM = R_W'(R_MIN);
  localparam logic [A_W-1:0] A_LIM = A_W'(A_MIN);

  main_word_t mw;
  ref_word_t  rw;
  aux_word_t  aw;
  test_word_t tw;

  always_comb begin
    mw = main_word_t'(word);
    rw = ref_word_t'(word);
    aw = aux_word_t'(word);
    tw = test_word_t'(word);
    main_o = '{fmod: mw.fmod, frac: mw.frac, ndiv: mw.ndiv};
    ref_o  = '{rdiv: rw.rdiv, lsel: lock_sel_e'(rw.lsel), pwr_main: rw.pwr_main,
               pwr_aux: rw.pwr_aux, fc: rw.fc};
    aux_o  = '{adiv: aw.adiv, cp: aw.cp, sm: aw.sm, sa: aw.sa};
    test_o = '{spd_dis: tw.spd_dis, spd_force: tw.spd_force};
    sel    = '0;
    valid  = 1'b0;
    case (mw.addr)
      2'b00: begin
        sel[SEL_MAIN] = 1'b1;
        valid = (mw.ndiv >= N_LIM) && (mw.spare == 2'b00);
      end
      2'b01: begin
        sel[SEL_REF] = 1'b1;
        valid = rw.rdiv >= R_LIM;
      end
      2'b10: begin
        sel[SEL_AUX] = 1'b1;
        valid = aw.adiv >= A_LIM;
      end
      default: begin
        if (tw.addr == 3'b110) begin
          sel[SEL_TEST] = 1'b1;
          valid = (tw.rsv_hi == '0) && (tw.rsv_lo == '0);
        end
      end
    endcase
  end
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_ctl_pkg::*;
#(
  parameter main_cfg_t MAIN_RST = '0,
  parameter ref_cfg_t  REF_RST  = '0,
  parameter aux_cfg_t  AUX_RST  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NSEL-1:0] sel,
  input  logic            valid,
  input  main_cfg_t       main_i,
  input  ref_cfg_t        ref_i,
  input  aux_cfg_t        aux_i,
  input  test_cfg_t       test_i,
  output main_cfg_t       main_q,
  output ref_cfg_t        ref_q,
  output aux_cfg_t        aux_q,
  output test_cfg_t       test_q,
  output logic            err_q
);
  logic            accept;
  logic [NSEL-1:0] wr_en;
  main_cfg_t       main_nx;
  ref_cfg_t        ref_nx;
  aux_cfg_t        aux_nx;
  test_cfg_t       test_nx;
  logic            err_nx;

  always_comb begin
    accept  = load & valid;
    wr_en   = sel & {NSEL{accept}};
    main_nx = wr_en[SEL_MAIN] ? main_i : main_q;
    ref_nx  = wr_en[SEL_REF]  ? ref_i  : ref_q;
    aux_nx  = wr_en[SEL_AUX]  ? aux_i  : aux_q;
    test_nx = wr_en[SEL_TEST] ? test_i : test_q;
    err_nx  = load ? ~valid : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= MAIN_RST;
      ref_q  <= REF_RST;
      aux_q  <= AUX_RST;
      test_q <= '0;
      err_q  <= 1'b0;
    end else begin
      main_q <= main_nx;
      ref_q  <= ref_nx;
      aux_q  <= aux_nx;
      test_q <= test_nx;
      err_q  <= err_nx;
    end
  end

  // R8: a rejected word leaves all registers untouched and raises the flag
  p_reject_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !valid) |=> ($stable(main_q) && $stable(ref_q) && $stable(aux_q)
                          && $stable(test_q) && err_q));
  // R8: an accepted word clears the flag
  p_accept_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid) |=> !err_q);
  // R12: no strobe edge, no register change
  p_no_edge_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(main_q) && $stable(ref_q) && $stable(aux_q)
               && $stable(test_q) && $stable(err_q)));
endmodule

// File: rtl/synth_lock_mux.sv
module synth_lock_mux
  import synth_ctl_pkg::*;
(
  input  logic      pol,
  input  logic      pwr_main,
  input  logic      pwr_aux,
  input  lock_sel_e lsel,
  input  logic      lk_main,
  input  logic      lk_aux,
  output logic      main_on,
  output logic      aux_on,
  output logic      lvl,
  output logic      drv
);
  logic comb_lock, picked;

  always_comb begin
    main_on   = pwr_main ^ pol;
    aux_on    = pwr_aux ^ pol;
    comb_lock = (~main_on | lk_main) & (~aux_on | lk_aux);
    case (lsel)
      LK_MAIN: picked = lk_main;
      LK_AUX:  picked = lk_aux;
      default: picked = comb_lock;
    endcase
    lvl = (main_on | aux_on) & picked;
    drv = (lsel == LK_COMB_OD) ? ~lvl : 1'b1;
  end
endmodule

// File: rtl/synth_ctl_bank.sv
module synth_ctl_bank
  import synth_ctl_pkg::*;
#(
  parameter int N_MIN = 512,
  parameter int R_MIN = 4,
  parameter int A_MIN = 128,
  parameter int N_RST = 2000,
  parameter int R_RST = 100,
  parameter int A_RST = 400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_data,
  input  logic        ser_clk,
  input  logic        ser_strobe,
  input  logic        pol_pin,
  input  logic        lock_main,
  input  logic        lock_aux,
  output logic        mod_sel,
  output logic [2:0]  frac_inc,
  output logic [15:0] main_div,
  output logic [9:0]  ref_div,
  output logic [7:0]  comp_code,
  output logic [13:0] aux_div,
  output logic [1:0]  cp_ratio,
  output logic [2:0]  main_cmp,
  output logic [2:0]  aux_cmp,
  output logic        spd_off,
  output logic        spd_on,
  output logic        main_en,
  output logic        aux_en,
  output logic        word_err,
  output logic        lock_level,
  output logic        lock_drive
);
  localparam main_cfg_t MAIN_RST = '{fmod: 1'b0, frac: 3'd0, ndiv: N_W'(N_RST)};
  localparam ref_cfg_t  REF_RST  = '{rdiv: R_W'(R_RST), lsel: LK_COMB_PP,
                                     pwr_main: 1'b0, pwr_aux: 1'b0, fc: '0};
  localparam aux_cfg_t  AUX_RST  = '{adiv: A_W'(A_RST), cp: 2'd0, sm: 3'd0, sa: 3'd0};

  logic rst_s1, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_int <= rst_s1;
    end
  end

  logic [WORD_W-1:0] word;
  logic              load, valid;
  logic [NSEL-1:0]   sel;
  main_cfg_t         main_d, main_q;
  ref_cfg_t          ref_d, ref_q;
  aux_cfg_t          aux_d, aux_q;
  test_cfg_t         test_d, test_q;

  synth_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int), .sdata(ser_data), .sclk(ser_clk),
    .sstb(ser_strobe), .word(word), .load(load)
  );

  synth_word_dec #(.N_MIN(N_MIN), .R_MIN(R_MIN), .A_MIN(A_MIN)) u_dec (
    .word(word), .sel(sel), .valid(valid), .main_o(main_d),
    .ref_o(ref_d), .aux_o(aux_d), .test_o(test_d)
  );

  synth_reg_bank #(.MAIN_RST(MAIN_RST), .REF_RST(REF_RST), .AUX_RST(AUX_RST)) u_regs (
    .clk(clk), .rst_n(rst_int), .load(load), .sel(sel), .valid(valid),
    .main_i(main_d), .ref_i(ref_d), .aux_i(aux_d), .test_i(test_d),
    .main_q(main_q), .ref_q(ref_q), .aux_q(aux_q), .test_q(test_q),
    .err_q(word_err)
  );

  synth_lock_mux u_lock (
    .pol(pol_pin), .pwr_main(ref_q.pwr_main), .pwr_aux(ref_q.pwr_aux),
    .lsel(ref_q.lsel), .lk_main(lock_main), .lk_aux(lock_aux),
    .main_on(main_en), .aux_on(aux_en), .lvl(lock_level), .drv(lock_drive)
  );

  assign mod_sel   = main_q.fmod;
  assign frac_inc  = main_q.frac;
  assign main_div  = main_q.ndiv;
  assign ref_div   = ref_q.rdiv;
  assign comp_code = ref_q.fc;
  assign aux_div   = aux_q.adiv;
  assign cp_ratio  = aux_q.cp;
  assign main_cmp  = aux_q.sm;
  assign aux_cmp   = aux_q.sa;
  assign spd_off   = test_q.spd_dis;
  assign spd_on    = test_q.spd_force;

  // R11: no enabled loop means a low lock pin
  p_off_low_r11: assert property (@(posedge clk) disable iff (!rst_int)
    (!main_en && !aux_en) |-> (!lock_level && lock_drive));
  // R10: open-drain mode releases the pin when the level is high
  p_od_release_r10: assert property (@(posedge clk) disable iff (!rst_int)
    (ref_q.lsel == LK_COMB_OD && lock_level) |-> !lock_drive);
  // R6: a stored main ratio never falls below its minimum
  p_main_floor_r6: assert property (@(posedge clk) disable iff (!rst_int)
    main_div >= N_W'(N_MIN));
  // R7: stored reference and auxiliary ratios stay at or above their minimums
  p_ref_aux_floor_r7: assert property (@(posedge clk) disable iff (!rst_int)
    (ref_div >= R_W'(R_MIN)) && (aux_div >= A_W'(A_MIN)));
endmodule

// File: tb/synth_ctl_bank_test.sv
`timescale 1ns/1ps
module synth_ctl_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_strobe = 1'b0;
  logic pol_pin = 1'b0, lock_main = 1'b0, lock_aux = 1'b0;
  logic        mod_sel;
  logic [2:0]  frac_inc;
  logic [15:0] main_div;
  logic [9:0]  ref_div;
  logic [7:0]  comp_code;
  logic [13:0] aux_div;
  logic [1:0]  cp_ratio;
  logic [2:0]  main_cmp, aux_cmp;
  logic spd_off, spd_on, main_en, aux_en, word_err, lock_level, lock_drive;

  always #2 clk = ~clk;

  synth_ctl_bank uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_strobe(ser_strobe), .pol_pin(pol_pin), .lock_main(lock_main),
    .lock_aux(lock_aux), .mod_sel(mod_sel), .frac_inc(frac_inc),
    .main_div(main_div), .ref_div(ref_div), .comp_code(comp_code),
    .aux_div(aux_div), .cp_ratio(cp_ratio), .main_cmp(main_cmp),
    .aux_cmp(aux_cmp), .spd_off(spd_off), .spd_on(spd_on), .main_en(main_en),
    .aux_en(aux_en), .word_err(word_err), .lock_level(lock_level),
    .lock_drive(lock_drive)
  );

  int vectors = 0;
  int fails = 0;

  // bench model of the register contents
  logic        m_fmod; logic [2:0] m_frac; logic [15:0] m_n;
  logic [9:0]  m_r; logic [1:0] m_lsel; logic m_pm, m_pa; logic [7:0] m_fc;
  logic [13:0] m_a; logic [1:0] m_cp; logic [2:0] m_sm, m_sa;
  logic        m_dis, m_spu, m_err;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [64:0] observe();
    return {mod_sel, frac_inc, main_div, ref_div, comp_code, aux_div, cp_ratio,
            main_cmp, aux_cmp, spd_off, spd_on, main_en, aux_en, word_err};
  endfunction

  function automatic logic [64:0] predict();
    return {m_fmod, m_frac, m_n, m_r, m_fc, m_a, m_cp, m_sm, m_sa, m_dis, m_spu,
            m_pm ^ pol_pin, m_pa ^ pol_pin, m_err};
  endfunction

  task automatic model_reset();
    m_fmod = 0; m_frac = 0; m_n = 16'd2000; m_r = 10'd100; m_lsel = 0;
    m_pm = 0; m_pa = 0; m_fc = 0; m_a = 14'd400; m_cp = 0; m_sm = 0; m_sa = 0;
    m_dis = 0; m_spu = 0; m_err = 0;
  endtask

  task automatic model_load(input logic [23:0] w);
    logic ok;
    ok = 1'b0;
    if (w[23:22] == 2'b00) begin
      ok = (w[17:2] >= 16'd512) && (w[1:0] == 2'b00);
      if (ok) begin m_fmod = w[21]; m_frac = w[20:18]; m_n = w[17:2]; end
    end else if (w[23:22] == 2'b01) begin
      ok = w[21:12] >= 10'd4;
      if (ok) begin m_r = w[21:12]; m_lsel = w[11:10]; m_pm = w[9]; m_pa = w[8]; m_fc = w[7:0]; end
    end else if (w[23:22] == 2'b10) begin
      ok = w[21:8] >= 14'd128;
      if (ok) begin m_a = w[21:8]; m_cp = w[7:6]; m_sm = w[5:3]; m_sa = w[2:0]; end
    end else if (w[21] == 1'b0) begin
      ok = (w[20:17] == 4'd0) && (w[14:0] == 15'd0);
      if (ok) begin m_dis = w[16]; m_spu = w[15]; end
    end
    m_err = ~ok;
  endtask

  task automatic expect_now(input string tag);
    exp_q.push_back(predict());
    tag_q.push_back(tag);
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); ser_data = w[i]; ser_clk = 1'b0;
      @(negedge clk); ser_clk = 1'b1;
    end
    @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic send(input logic [23:0] w, input string tag);
    shift_word(w);
    @(negedge clk); ser_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk); ser_strobe = 1'b0;
    model_load(w);
    expect_now(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares with the ports
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [64:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (observe() !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, observe(), e);
      end
    end
  end

  task automatic chk_lock(input logic lm, input logic la, input logic e_lvl,
                          input logic e_drv, input string tag);
    @(negedge clk); lock_main = lm; lock_aux = la;
    @(negedge clk);
    vectors++;
    if (lock_level !== e_lvl || lock_drive !== e_drv) begin
      fails++;
      $display("FAIL %s: got lvl=%b drv=%b expected lvl=%b drv=%b",
               tag, lock_level, lock_drive, e_lvl, e_drv);
    end
  endtask

  function automatic logic [23:0] w_main(logic f, logic [2:0] nf, logic [15:0] n, logic [1:0] sp);
    return {2'b00, f, nf, n, sp};
  endfunction
  function automatic logic [23:0] w_ref(logic [9:0] r, logic [1:0] l, logic pm, logic pa, logic [7:0] fc);
    return {2'b01, r, l, pm, pa, fc};
  endfunction
  function automatic logic [23:0] w_aux(logic [13:0] a, logic [1:0] cp, logic [2:0] sm, logic [2:0] sa);
    return {2'b10, a, cp, sm, sa};
  endfunction
  function automatic logic [23:0] w_test(logic d, logic s, logic [3:0] hi, logic [14:0] lo);
    return {3'b110, hi, d, s, lo};
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R1 reset state");
    @(negedge clk); @(negedge clk);

    send(w_main(1'b1, 3'd5, 16'd40000, 2'b00), "R2 main word");
    send(w_ref(10'd1023, 2'b01, 1'b1, 1'b0, 8'd200), "R3 ref word / R9 pol low");
    send(w_aux(14'd16383, 2'd2, 3'd5, 3'd3), "R4 aux word");
    send(w_test(1'b1, 1'b0, 4'd0, 15'd0), "R5 test disable");
    send(w_test(1'b0, 1'b1, 4'd0, 15'd0), "R5 test force on");
    send(w_test(1'b1, 1'b1, 4'd2, 15'd0), "R5 reserved high bit rejected");
    send(w_test(1'b1, 1'b1, 4'd0, 15'h4000), "R5 reserved low bit rejected");
    send({3'b111, 21'h1FFFFF}, "R5 prefix 111 rejected");
    send(w_main(1'b0, 3'd7, 16'd511, 2'b00), "R6 main ratio 511 rejected");
    send(w_main(1'b0, 3'd7, 16'd512, 2'b00), "R6 main ratio 512 accepted / R8 err clear");
    send(w_main(1'b1, 3'd1, 16'd9000, 2'b01), "R6 spare bit rejected");
    send(w_ref(10'd3, 2'b10, 1'b0, 1'b1, 8'd1), "R7 ref ratio 3 rejected");
    send(w_ref(10'd4, 2'b10, 1'b0, 1'b1, 8'd1), "R7 ref ratio 4 accepted");
    send(w_aux(14'd127, 2'd1, 3'd1, 3'd1), "R7 aux ratio 127 rejected");
    send(w_aux(14'd128, 2'd1, 3'd6, 3'd2), "R7 aux ratio 128 accepted / R8 only aux changes");

    // R9: polarity flip with stored power bits main=0 aux=1
    @(negedge clk); pol_pin = 1'b1;
    expect_now("R9 pol high inverts enables");
    @(negedge clk); @(negedge clk);
    @(negedge clk); pol_pin = 1'b0;
    expect_now("R9 pol low restores enables");
    @(negedge clk); @(negedge clk);

    // R10 / R11: lock pin source and drive
    send(w_ref(10'd100, 2'b00, 1'b1, 1'b1, 8'd0), "R10 setup comb push-pull");
    chk_lock(1'b1, 1'b0, 1'b0, 1'b1, "R10 comb pp aux unlocked");
    chk_lock(1'b1, 1'b1, 1'b1, 1'b1, "R10 comb pp both locked");
    send(w_ref(10'd100, 2'b01, 1'b1, 1'b1, 8'd0), "R10 setup comb open-drain");
    chk_lock(1'b1, 1'b1, 1'b1, 1'b0, "R10 comb od released");
    chk_lock(1'b0, 1'b1, 1'b0, 1'b1, "R10 comb od pulled low");
    send(w_ref(10'd100, 2'b10, 1'b1, 1'b1, 8'd0), "R10 setup main only");
    chk_lock(1'b1, 1'b0, 1'b1, 1'b1, "R10 main only");
    send(w_ref(10'd100, 2'b11, 1'b1, 1'b1, 8'd0), "R10 setup aux only");
    chk_lock(1'b1, 1'b0, 1'b0, 1'b1, "R10 aux only unlocked");
    chk_lock(1'b0, 1'b1, 1'b1, 1'b1, "R10 aux only locked");
    send(w_ref(10'd100, 2'b00, 1'b1, 1'b0, 8'd0), "R10 setup comb aux off");
    chk_lock(1'b1, 1'b0, 1'b1, 1'b1, "R10 comb ignores disabled aux");
    send(w_ref(10'd100, 2'b10, 1'b0, 1'b0, 8'd0), "R11 setup both off");
    chk_lock(1'b1, 1'b1, 1'b0, 1'b1, "R11 both off forces low");
    send(w_ref(10'd100, 2'b01, 1'b0, 1'b0, 8'd0), "R11 setup both off od");
    chk_lock(1'b1, 1'b1, 1'b0, 1'b1, "R11 both off open-drain low");

    // R12: shifting under a held strobe does not load
    shift_word(w_main(1'b0, 3'd2, 16'd1234, 2'b00));
    @(negedge clk); ser_strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    model_load(w_main(1'b0, 3'd2, 16'd1234, 2'b00));
    expect_now("R12 first word loaded");
    shift_word(w_main(1'b1, 3'd6, 16'd5555, 2'b00));
    @(negedge clk); ser_strobe = 1'b0;
    expect_now("R12 held strobe ignores second word");
    @(negedge clk); @(negedge clk);
    @(negedge clk); ser_strobe = 1'b1;
    @(negedge clk); @(negedge clk); ser_strobe = 1'b0;
    model_load(w_main(1'b1, 3'd6, 16'd5555, 2'b00));
    expect_now("R12 fresh edge loads second word");
    repeat (4) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule